// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters written by a host into frames on a single asynchronous serial line. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional odd or even parity bit, and a high stop period of one, one and a half or two bit times. The line idles high. Bit timing comes from a transmit clock-enable input. A bit lasts 1, 16 or 64 of its pulses, chosen by a divisor field.

The host writes into a one-character holding register. When the shift stage is free, the held character moves into it and the holding register frees up at once. This allows characters to follow one another with no idle gap. Two status outputs report that the holding register can take a character and that the whole transmitter has drained. A transmit-enable input stops new characters from starting. A break request forces the line low for as long as it stays asserted. The format fields are captured when a character enters the shift stage, so they may be changed for the next character while one is on the line.

Top module: `sertx_top`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the stop period. `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `wr_data` above the selected length are never sent.
- R2: With `par_en`=1, one parity bit follows the last data bit. It equals the XOR of the sent data bits when `par_even`=1 and the inverse of that XOR when `par_even`=0. With `par_en`=0, no parity bit is sent and `par_even` has no effect.
- R3: `stop_sel` values 1, 2 and 3 give a high stop period of 1, 1.5 and 2 bit times, and value 0 behaves as 1. The period is counted in half bits. At a 1-pulse bit time, 1.5 rounds up to 2 bit times.
- R4: `div_sel` values 1, 2 and 3 make a bit time last 1, 16 and 64 pulses of `tick_en`, and value 0 behaves as 1. Cycles with `tick_en`=0 do not advance the bit timing.
- R5: `tx_ready` is 1 exactly when the holding register is empty. A write (`wr_en`=1) while `tx_ready`=0 is dropped and leaves the held character unchanged.
- R6: `tx_empty` is 1 only when nothing is held and nothing is being shifted.
- R7: While `brk_req`=1, `tx_line` is 0. Once it returns to 0, the line shows the normal frame or idle level again.
- R8: A held character enters the shift stage in the cycle the stage becomes free: one cycle after a write to an idle transmitter, or the last cycle of the previous stop period, which leaves no idle gap.
- R9: While `tx_enable`=0, no new character starts and a held character stays held. A frame already under way completes in full.
- R10: After reset, `tx_line`=1, `tx_ready`=1 and `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Transmit clock enable; one pulse is one unit of bit time |
| tx_enable | input | 1 | Permits new characters to start |
| brk_req | input | 1 | Forces the line low while 1 |
| len_sel | input | 2 | Data length select (5 + value bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| stop_sel | input | 2 | Stop period select |
| div_sel | input | 2 | Bit time divisor select |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing held and nothing shifting |
| tx_line | output | 1 | Serial output |

## Verification
The closest timing overlap in this block is the final cycle of one character's stop period, which is also the cycle in which the next held character is taken into the shift stage. The bench provokes it by writing each following character as soon as `tx_ready` rises, while the previous frame is still being sent. The monitor then requires the line to be high for every cycle of the expected stop period and low in the very next cycle, at exactly 1x and at 16x with a fractional stop length. When no character is waiting, the same cycle must instead show the line still high.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CHAR_W  = 8;
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic [1:0] stop;
    logic [1:0] div;
  } tx_fmt_t;

  // enable pulses per bit time
  function automatic int unsigned bit_ticks(input logic [1:0] div,
                                            input int unsigned mid,
                                            input int unsigned high);
    case (div)
      2'd2:    return mid;
      2'd3:    return high;
      default: return 1;
    endcase
  endfunction

  // stop period in enable pulses: half-bit units, rounded up
  function automatic int unsigned stop_ticks(input logic [1:0] stop,
                                             input int unsigned bt);
    int unsigned halves;
    case (stop)
      2'd2:    halves = 3;
      2'd3:    halves = 4;
      default: halves = 2;
    endcase
    return (bt * halves + 1) / 2;
  endfunction

  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len);
    return {CHAR_W{1'b1}} >> (3 - int'(len));
  endfunction

endpackage

// File: rtl/sertx_timer.sv
module sertx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = tick_en && (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || done) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt_q)); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit); // R4

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] data_i,
  input  tx_fmt_t           fmt_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              line_o
);

  tx_state_e         st_q, st_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [2:0]        idx_q, idx_d;
  tx_fmt_t           fmt_q, fmt_d;
  logic              par_q, par_d;

  logic [CNT_W-1:0]  bit_lim, limit;
  logic              done;
  logic [2:0]        idx_last;
  logic [CHAR_W-1:0] masked;

  assign bit_lim  = CNT_W'(bit_ticks(fmt_q.div, DIV_MID, DIV_HIGH));
  assign limit    = (st_q == ST_STOP)
                  ? CNT_W'(stop_ticks(fmt_q.stop, bit_ticks(fmt_q.div, DIV_MID, DIV_HIGH)))
                  : bit_lim;
  assign idx_last = 3'(MIN_LEN - 1) + {1'b0, fmt_q.len};
  assign masked   = data_i & len_mask(fmt_i.len);

  sertx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .restart (load_i),
    .limit   (limit),
    .done    (done)
  );

  assign accept_o = (st_q == ST_IDLE) || ((st_q == ST_STOP) && done);
  assign busy_o   = (st_q != ST_IDLE);

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    idx_d = idx_q;
    fmt_d = fmt_q;
    par_d = par_q;
    case (st_q)
      ST_START: if (done) begin
        st_d  = ST_DATA;
        idx_d = '0;
      end
      ST_DATA: if (done) begin
        sh_d = sh_q >> 1;
        if (idx_q == idx_last) begin
          st_d = fmt_q.par_en ? ST_PAR : ST_STOP;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAR:  if (done) st_d = ST_STOP;
      ST_STOP: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (load_i) begin
      st_d  = ST_START;
      sh_d  = masked;
      fmt_d = fmt_i;
      par_d = (^masked) ^ ~fmt_i.par_even;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      fmt_q <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
      fmt_q <= fmt_d;
      par_q <= par_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (st_q == ST_START)); // R8

  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> $stable(fmt_q)); // R1

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       tx_enable,
  input  logic       brk_req,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic [1:0] stop_sel,
  input  logic [1:0] div_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       tx_ready,
  output logic       tx_empty,
  output logic       tx_line
);

  localparam int CNT_W = $clog2(2 * DIV_HIGH + 1);

  logic              rst_meta_n, rst_sync_n;
  logic              hold_valid_q, hold_valid_d;
  logic [CHAR_W-1:0] hold_data_q, hold_data_d;
  logic              sh_accept, sh_busy, sh_line, load;
  tx_fmt_t           fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign fmt  = '{len: len_sel, par_en: par_en, par_even: par_even,
                  stop: stop_sel, div: div_sel};
  assign load = sh_accept && hold_valid_q && tx_enable;

  always_comb begin
    hold_valid_d = hold_valid_q;
    hold_data_d  = hold_data_q;
    if (load) begin
      hold_valid_d = 1'b0;
    end else if (wr_en && !hold_valid_q) begin
      hold_valid_d = 1'b1;
      hold_data_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
    end else begin
      hold_valid_q <= hold_valid_d;
      hold_data_q  <= hold_data_d;
    end
  end

  sertx_shifter #(
    .DIV_MID  (DIV_MID),
    .DIV_HIGH (DIV_HIGH),
    .CNT_W    (CNT_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .load_i   (load),
    .data_i   (hold_data_q),
    .fmt_i    (fmt),
    .accept_o (sh_accept),
    .busy_o   (sh_busy),
    .line_o   (sh_line)
  );

  assign tx_ready = !hold_valid_q;
  assign tx_empty = !hold_valid_q && !sh_busy;
  assign tx_line  = sh_line && !brk_req;

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hold_valid_q && !load) |=> (hold_valid_q && $stable(hold_data_q))); // R5

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_empty |-> tx_ready); // R6

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_enable && !sh_busy) |=> !sh_busy); // R9

endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;

  typedef struct {
    logic [7:0] d;
    logic [1:0] len;
    logic       pe;
    logic       ev;
    logic [1:0] st;
    logic [1:0] dv;
  } frm_t;

  logic clk = 1'b0;
  logic rst_n, tick_en, tx_enable, brk_req, par_en, par_even, wr_en;
  logic [1:0] len_sel, stop_sel, div_sel;
  logic [7:0] wr_data;
  logic tx_ready, tx_empty, tx_line;

  int nchk = 0, nerr = 0, tp = 1;
  bit mon_on = 1'b0, mon_busy = 1'b0, fin = 1'b0;
  frm_t q[$];

  always #2 clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_enable(tx_enable),
    .brk_req(brk_req), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
    .stop_sel(stop_sel), .div_sel(div_sel), .wr_en(wr_en), .wr_data(wr_data),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bt_of(input logic [1:0] dv);
    if (dv == 2'd2) return 16;
    if (dv == 2'd3) return 64;
    return 1;
  endfunction

  function automatic int stop_of(input logic [1:0] st, input int bt);
    if (st == 2'd3) return 2 * bt;
    if (st == 2'd2) return (bt == 1) ? 2 : (3 * bt) / 2;
    return bt;
  endfunction

  // transmit clock-enable pattern: one pulse every tp cycles
  initial begin
    int c = 0;
    tick_en = 1'b1;
    forever begin
      @(negedge clk);
      c = (c + 1) % tp;
      tick_en = (c == 0);
    end
  end

  task automatic set_fmt(input logic [1:0] l, input logic p, input logic e,
                         input logic [1:0] s, input logic [1:0] d);
    len_sel = l; par_en = p; par_even = e; stop_sel = s; div_sel = d;
  endtask

  task automatic wr_raw(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: waits for room, writes, records the expected frame
  task automatic send(input logic [7:0] v);
    frm_t f;
    while (!tx_ready) @(negedge clk);
    f.d = v; f.len = len_sel; f.pe = par_en; f.ev = par_even;
    f.st = stop_sel; f.dv = div_sel;
    q.push_back(f);
    wr_raw(v);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!(tx_empty && !mon_busy && q.size() == 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 20000, "R6 drain timeout", n, 0);
  endtask

  // monitor: entered at the negedge where the start bit is first seen
  task automatic frame_mon(output bit chained);
    frm_t f;
    int b, nb, s, ones;
    logic pbit;
    chained = 1'b0;
    if (q.size() == 0) begin
      chk(1'b0, "R1 unexpected frame", 1, 0);
      return;
    end
    f = q.pop_front();
    b  = bt_of(f.dv) * tp;
    nb = 5 + int'(f.len);
    negs(b / 2);
    chk(tx_line == 1'b0, "R1 start bit", tx_line, 0);
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      negs(b);
      ones += int'(f.d[i]);
      chk(tx_line == f.d[i], "R1 R4 data bit", tx_line, f.d[i]);
    end
    if (f.pe) begin
      pbit = f.ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
      negs(b);
      chk(tx_line == pbit, "R2 parity bit", tx_line, pbit);
    end
    negs(b - b / 2);
    s = stop_of(f.st, bt_of(f.dv)) * tp;
    if (tp == 1) begin
      for (int j = 0; j < s; j++) begin
        chk(tx_line == 1'b1, "R3 stop level", tx_line, 1);
        negs(1);
      end
      if (q.size() > 0) begin
        chk(tx_line == 1'b0, "R8 back-to-back start", tx_line, 0);
        chained = 1'b1;
      end else begin
        chk(tx_line == 1'b1, "R3 stop length", tx_line, 1);
      end
    end else begin
      negs(s / 2);
      chk(tx_line == 1'b1, "R3 R4 stop level", tx_line, 1);
    end
  endtask

  initial begin
    bit prev = 1'b1, chain = 1'b0;
    forever begin
      if (!chain) begin
        @(negedge clk);
        if (!(mon_on && prev && !tx_line)) begin
          prev = tx_line;
          continue;
        end
      end
      mon_busy = 1'b1;
      frame_mon(chain);
      mon_busy = 1'b0;
      prev = tx_line;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_enable = 1'b1; brk_req = 1'b0; wr_en = 1'b0; wr_data = '0;
    set_fmt(2'd3, 1'b0, 1'b0, 2'd1, 2'd1);
    negs(3);
    rst_n = 1'b1;
    negs(4);
    // R10 reset state
    chk(tx_line == 1'b1, "R10 line idle", tx_line, 1);
    chk(tx_ready == 1'b1, "R10 ready", tx_ready, 1);
    chk(tx_empty == 1'b1, "R10 empty", tx_empty, 1);
    mon_on = 1'b1;

    // 8 data, no parity, 1 stop, 1x: status sequence, then back-to-back
    send(8'hA5);
    chk(tx_ready == 1'b0, "R5 ready after write", tx_ready, 0);
    chk(tx_empty == 1'b0, "R6 empty after write", tx_empty, 0);
    negs(1);
    chk(tx_ready == 1'b1, "R8 buffer freed", tx_ready, 1);
    chk(tx_empty == 1'b0, "R6 busy shifting", tx_empty, 0);
    send(8'h3C); send(8'hFF); send(8'h00);
    wait_idle();

    // 7 data, even parity, 2 stop; bit 7 must not appear
    set_fmt(2'd2, 1'b1, 1'b1, 2'd3, 2'd1);
    send(8'hDB); send(8'h01);
    wait_idle();

    // 5 data, odd parity, 1.5 stop at 1x rounds to 2
    set_fmt(2'd0, 1'b1, 1'b0, 2'd2, 2'd1);
    send(8'h1F); send(8'hEA);
    wait_idle();

    // 6 data, parity off with even select set, stop code 0, divisor code 0
    set_fmt(2'd1, 1'b0, 1'b1, 2'd0, 2'd0);
    send(8'h2A); send(8'h15);
    wait_idle();

    // 16x, 8 data, even parity, 1.5 stop, back-to-back
    set_fmt(2'd3, 1'b1, 1'b1, 2'd2, 2'd2);
    send(8'h96); send(8'h69);
    wait_idle();

    // 16x with enable every second cycle (R4), 6 data odd parity
    tp = 2;
    set_fmt(2'd1, 1'b1, 1'b0, 2'd1, 2'd2);
    send(8'h15);
    wait_idle();
    tp = 1;
    negs(2);

    // 64x, 8 data, 2 stop
    set_fmt(2'd3, 1'b0, 1'b0, 2'd3, 2'd3);
    send(8'hC3);
    wait_idle();

    // R9 gating and R5 dropped write
    set_fmt(2'd3, 1'b0, 1'b0, 2'd1, 2'd1);
    tx_enable = 1'b0;
    send(8'h11);
    wr_raw(8'h22);
    negs(10);
    chk(tx_line == 1'b1, "R9 no start while disabled", tx_line, 1);
    chk(tx_ready == 1'b0, "R9 R5 char still held", tx_ready, 0);
    chk(tx_empty == 1'b0, "R9 R6 not empty while held", tx_empty, 0);
    tx_enable = 1'b1;
    wait_idle();
    chk(tx_ready == 1'b1, "R5 ready after drain", tx_ready, 1);

    // R9 frame in flight completes after disable
    set_fmt(2'd3, 1'b0, 1'b0, 2'd1, 2'd2);
    send(8'h77);
    negs(40);
    tx_enable = 1'b0;
    wait_idle();
    tx_enable = 1'b1;

    // R7 break
    mon_on = 1'b0;
    brk_req = 1'b1;
    negs(3);
    chk(tx_line == 1'b0, "R7 break low", tx_line, 0);
    negs(5);
    chk(tx_line == 1'b0, "R7 break held", tx_line, 0);
    brk_req = 1'b0;
    negs(1);
    chk(tx_line == 1'b1, "R7 line released", tx_line, 1);
    chk(q.size() == 0, "R1 all frames seen", q.size(), 0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule